// File: doc/BRIEF.md
# Framebuffer Line Scan Address Generator

This block walks a framebuffer once per frame and hands a memory fetch engine one start address per display line. At the start of each frame it captures the panel geometry from the decoded control fields: the line count, the pixel width and the pixel depth code. From these it works out how many source bytes one line occupies. The first line of a frame starts at the framebuffer base. The base is derived from the start-address word by shifting it left one place and clearing bit 0 and bit 31.

The consumer sees `line_valid` with a line address and acknowledges each line with `line_ack`. The block then steps to the next line, one stride further on. When the last line of the frame is acknowledged, the block raises `frame_done` for one cycle and rewinds to the base, ready for the next frame. Clearing `enable` halts scanning, and so does an unsupported depth code. Fetching memory and unpacking pixels are left to other blocks.

Top module: `fb_line_scanner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `line_valid`, `frame_done`, `line_addr` and `line_bytes` are all zero.
- R2: A frame has `height_field`+1 lines. After the acknowledge of the last line, `frame_done` is high for exactly one cycle, the one that follows that acknowledge.
- R3: Pixel width is `width_field`+1. Bytes per line depend on `depth_code`:
  - code 0 (1 bpp): width/8
  - code 1 (2 bpp): width/4
  - code 2 (4 bpp): width/2
  - code 3 (8 bpp): width
  - code 4 (12 bpp): (width*3)/2
  - code 5 (16 bpp): width*2
  - code 6 (24 bpp): width*4
- R4: The first line of each frame is at `{1'b0, start_word[29:0], 1'b0}`, which is (start_word << 1) AND 0x7FFFFFFE.
- R5: Each acknowledged line that is not the last advances `line_addr` by the current `line_bytes`.
- R6: With `enable` low, `line_valid` is low from the next cycle onward. Acknowledges in that state leave `line_addr` unchanged. When `enable` returns, scanning restarts from the base.
- R7: Depth codes 7 to 15 are unsupported. While one is applied at a frame start, no line is issued.
- R8: Changes to width, height or depth during a frame do not alter `line_bytes` or the address step until the next frame begins.
- R9: In the cycle where `frame_done` is high with `enable` still set, `line_addr` is back at the base and `line_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Display enable |
| height_field | input | 10 | Line count minus one |
| width_field | input | 11 | Pixel width minus one |
| depth_code | input | 4 | Pixel depth selector |
| start_word | input | 32 | Start-address word |
| line_ack | input | 1 | Consumer accepts current line |
| line_addr | output | 32 | Byte address of current line |
| line_valid | output | 1 | Line address is valid |
| line_bytes | output | 16 | Source bytes per line for this frame |
| frame_done | output | 1 | One-cycle frame-sync pulse |

## Verification
A wrong line counter shows up as `frame_done` arriving one acknowledge early or late, and it is visible on the frame's final acknowledge. A wrong stride, or a geometry register that is latched at the wrong moment, shows up in `line_addr` on the very next acknowledge after the fault. A fault in the enable or depth gating shows as `line_valid` being asserted or held one cycle after it should drop.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
    localparam int ADDR_W   = 32;
    localparam int HEIGHT_W = 10;
    localparam int WIDTH_W  = 11;
    localparam int BYTES_W  = 16;

    typedef enum logic [3:0] {
        DEPTH_1  = 4'd0,
        DEPTH_2  = 4'd1,
        DEPTH_4  = 4'd2,
        DEPTH_8  = 4'd3,
        DEPTH_12 = 4'd4,
        DEPTH_16 = 4'd5,
        DEPTH_24 = 4'd6
    } depth_e;

    typedef struct packed {
        logic [HEIGHT_W-1:0] last_line;
        logic [BYTES_W-1:0]  bytes;
    } geom_t;

    function automatic logic [BYTES_W-1:0] stride_of(input logic [3:0] code,
                                                     input logic [BYTES_W-1:0] w);
        logic [BYTES_W-1:0] r;
        case (code)
            DEPTH_1:  r = w >> 3;
            DEPTH_2:  r = w >> 2;
            DEPTH_4:  r = w >> 1;
            DEPTH_8:  r = w;
            DEPTH_12: r = (w + (w << 1)) >> 1;
            DEPTH_16: r = w << 1;
            DEPTH_24: r = w << 2;
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic logic code_ok(input logic [3:0] code);
        return code <= 4'(DEPTH_24);
    endfunction
endpackage

// File: rtl/fbscan_geom.sv
module fbscan_geom
    import fbscan_pkg::*;
(
    input  logic [HEIGHT_W-1:0] height_field,
    input  logic [WIDTH_W-1:0]  width_field,
    input  logic [3:0]          depth_code,
    output geom_t               geom,
    output logic                geom_ok
);
    logic [BYTES_W-1:0] pix_w;

    always_comb begin
        pix_w          = BYTES_W'(width_field) + 1'b1;
        geom.last_line = height_field;
        geom.bytes     = stride_of(depth_code, pix_w);
        geom_ok        = code_ok(depth_code);
    end
endmodule

// File: rtl/fbscan_seq.sv
module fbscan_seq
    import fbscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              line_ack,
    input  geom_t             geom_in,
    input  logic              geom_ok,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic              scanning,
    output geom_t             cur,
    output logic              done
);
    logic [HEIGHT_W-1:0] line_idx;
    logic                start_ok;

    assign start_ok = enable && geom_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            scanning <= 1'b0;
            addr     <= '0;
            cur      <= '0;
            line_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (scanning && !enable) begin
                scanning <= 1'b0;
            end else if (!scanning) begin
                if (start_ok) begin
                    scanning <= 1'b1;
                    cur      <= geom_in;
                    addr     <= base;
                    line_idx <= '0;
                end
            end else if (line_ack) begin
                if (line_idx == cur.last_line) begin
                    done     <= 1'b1;
                    addr     <= base;
                    line_idx <= '0;
                    if (start_ok) cur <= geom_in;
                    else          scanning <= 1'b0;
                end else begin
                    addr     <= addr + ADDR_W'(cur.bytes);
                    line_idx <= line_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fb_line_scanner.sv
module fb_line_scanner
    import fbscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic [9:0]  height_field,
    input  logic [10:0] width_field,
    input  logic [3:0]  depth_code,
    input  logic [31:0] start_word,
    input  logic        line_ack,
    output logic [31:0] line_addr,
    output logic        line_valid,
    output logic [15:0] line_bytes,
    output logic        frame_done
);
    geom_t             geom_next;
    geom_t             geom_cur;
    logic              geom_ok;
    logic [ADDR_W-1:0] base;

    assign base = {1'b0, start_word[ADDR_W-3:0], 1'b0};

    fbscan_geom u_geom (
        .height_field (height_field),
        .width_field  (width_field),
        .depth_code   (depth_code),
        .geom         (geom_next),
        .geom_ok      (geom_ok)
    );

    fbscan_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .line_ack (line_ack),
        .geom_in  (geom_next),
        .geom_ok  (geom_ok),
        .base     (base),
        .addr     (line_addr),
        .scanning (line_valid),
        .cur      (geom_cur),
        .done     (frame_done)
    );

    assign line_bytes = geom_cur.bytes;
endmodule

// File: rtl/fbscan_chk.sv
module fbscan_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        line_ack,
    input logic [31:0] line_addr,
    input logic        line_valid,
    input logic [15:0] line_bytes,
    input logic        frame_done
);
    // R2
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(line_valid && line_ack && enable));
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(line_valid && line_ack && enable) && !frame_done)
            |-> line_addr == $past(line_addr) + 32'($past(line_bytes)));
    // R6
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !line_valid);
    // R8
    bytes_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(line_valid) && line_valid && !frame_done) |-> $stable(line_bytes));
    // R4
    base_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> (line_addr[0] == 1'b0 || !frame_done));
endmodule

bind fb_line_scanner fbscan_chk u_fbscan_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .line_ack   (line_ack),
    .line_addr  (line_addr),
    .line_valid (line_valid),
    .line_bytes (line_bytes),
    .frame_done (frame_done)
);

// File: tb/fb_line_scanner_bench.sv
module fb_line_scanner_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [9:0]  height_field = '0;
    logic [10:0] width_field = '0;
    logic [3:0]  depth_code = '0;
    logic [31:0] start_word = '0;
    logic        line_ack = 1'b0;
    logic [31:0] line_addr;
    logic        line_valid;
    logic [15:0] line_bytes;
    logic        frame_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    fb_line_scanner u_fb_line_scanner (
        .clk(clk), .rst(rst), .enable(enable), .height_field(height_field),
        .width_field(width_field), .depth_code(depth_code), .start_word(start_word),
        .line_ack(line_ack), .line_addr(line_addr), .line_valid(line_valid),
        .line_bytes(line_bytes), .frame_done(frame_done)
    );

    // {valid, depth[3:0], width_field[10:0], expected bytes[15:0]}
    localparam logic [31:0] VEC [8] = '{
        {1'b1, 4'd0, 11'd63,   16'd8},
        {1'b1, 4'd1, 11'd99,   16'd25},
        {1'b1, 4'd2, 11'd319,  16'd160},
        {1'b1, 4'd3, 11'd239,  16'd240},
        {1'b1, 4'd4, 11'd9,    16'd15},
        {1'b1, 4'd5, 11'd2047, 16'd4096},
        {1'b1, 4'd6, 11'd799,  16'd3200},
        {1'b0, 4'd9, 11'd15,   16'd0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] b;
        logic [31:0] step;
        b = 32'h0000_2468;
        @(negedge clk);
        tick();
        chk(!line_valid && !frame_done && line_addr == 0 && line_bytes == 0, "R1 reset", line_addr, 0);
        rst = 1'b0;
        tick();
        chk(!line_valid && line_addr == 0, "R1 after reset", line_valid, 0);

        // table walk
        start_word   = 32'hC000_1234;
        height_field = 10'd2;
        for (int i = 0; i < 8; i++) begin
            depth_code  = VEC[i][30:27];
            width_field = VEC[i][26:16];
            step        = {16'd0, VEC[i][15:0]};
            enable      = 1'b1;
            tick();
            if (!VEC[i][31]) begin
                tick();
                chk(!line_valid, "R7 bad depth", line_valid, 0);
            end else begin
                chk(line_valid && line_bytes == VEC[i][15:0], "R3 stride", line_bytes, VEC[i][15:0]);
                chk(line_addr == b, "R4 base", line_addr, b);
                line_ack = 1'b1;
                tick();
                chk(line_addr == b + step && !frame_done, "R5 step1", line_addr, b + step);
                tick();
                chk(line_addr == b + 2 * step && !frame_done, "R5 step2", line_addr, b + 2 * step);
                tick();
                chk(frame_done, "R2 done after height+1", frame_done, 1);
                chk(line_valid && line_addr == b, "R9 wrap", line_addr, b);
                line_ack = 1'b0;
                tick();
                chk(!frame_done, "R2 single pulse", frame_done, 0);
            end
            enable = 1'b0;
            tick();
            chk(!line_valid, "R6 disabled", line_valid, 0);
        end

        // base masking
        start_word   = 32'h3FFF_FFFF;
        depth_code   = 4'd3;
        width_field  = 11'd15;
        height_field = 10'd1;
        enable       = 1'b1;
        tick();
        chk(line_addr == 32'h7FFF_FFFE, "R4 mask", line_addr, 32'h7FFF_FFFE);
        enable = 1'b0;
        tick();

        // mid-frame config change
        start_word = 32'h0000_1000;
        b          = 32'h0000_2000;
        enable     = 1'b1;
        tick();
        chk(line_bytes == 16, "R3 8bpp", line_bytes, 16);
        line_ack   = 1'b1;
        depth_code = 4'd5;
        tick();
        chk(line_bytes == 16 && line_addr == b + 16, "R8 held in frame", line_addr, b + 16);
        tick();
        chk(frame_done && line_bytes == 32 && line_addr == b, "R8 new frame", line_bytes, 32);

        // enable drop mid-frame
        line_ack = 1'b0;
        tick();
        line_ack = 1'b1;
        tick();
        chk(line_addr == b + 32, "R5 step 16bpp", line_addr, b + 32);
        enable = 1'b0;
        tick();
        chk(!line_valid && line_addr == b + 32, "R6 stop", line_addr, b + 32);
        tick();
        chk(!line_valid && line_addr == b + 32 && !frame_done, "R6 ack ignored", line_addr, b + 32);
        line_ack = 1'b0;
        enable   = 1'b1;
        tick();
        chk(line_valid && line_addr == b, "R6 restart at base", line_addr, b);

        // invalid depth at frame end halts
        line_ack   = 1'b1;
        tick();
        depth_code = 4'd15;
        tick();
        chk(frame_done, "R2 done with bad depth", frame_done, 1);
        tick();
        chk(!line_valid, "R7 halted", line_valid, 0);
        line_ack = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule